// File: doc/BRIEF.md
# LIN Wake-Up and Resynchronization Sequencer

This block sequences the wake-up and recovery behaviour that sits beside a LIN protocol engine. Software writes a small control register holding a resynchronize bit, a one-shot wake-up request, a two-bit delimiter-time select and a debug bit. When a wake-up request is accepted, the block pulls the transmit line dominant (low) for a fixed number of bit times. It then releases the line and waits a selectable delimiter time, counted in bit-time strobes from the baud generator, before it raises transmit-ready.

The block also owns the engine's return to its start state. A set resynchronize bit holds the engine in reset until software clears it. Any bus exception (bit error, physical bus error, wake-up detection) restarts the engine automatically unless the debug bit is set. A sleep-status input keeps transmit-ready low until a full wake-up sequence has run since the bus last went to sleep. Baud generation, frame transmission and frame reception are outside this block. The bit-time strobe is an input.

Top module: `lin_wake_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it, every control field reads 0, `txd_o` is 1 (recessive), `tx_ready_o` is 0 and `eng_reset_o` is 0.
- R2: Control word layout for writes and reads: bit 0 resync, bit 1 wake request, bits 3:2 delimiter select, bit 4 debug. `rd_data_o` returns the stored fields one cycle after an accepted write. Bit 1 always reads 0 because the request clears itself.
- R3: A write while `tx_busy_i` is 1 has no effect. No field changes and no wake-up starts.
- R4: An accepted wake request (bit 1 = 1, bit 0 = 0, with no sequence running and resync clear) drives `txd_o` to 0 from the next cycle. The line stays low until PULSE_TICKS (default 8) bit strobes have been counted, and is then released to 1.
- R5: After the pulse, the block waits a delimiter of 4, 8, 32 or 64 bit strobes, for select codes 0, 1, 2 and 3. The select is taken at the request. `tx_ready_o` stays 0 for the whole pulse and delimiter.
- R6: `tx_ready_o` rises in the cycle after the clock edge that counts the last delimiter strobe, provided resync is clear and the bus is not asleep without a completed wake-up.
- R7: A wake request that arrives while a pulse or delimiter is running is dropped. It is not queued, and the running sequence continues unchanged.
- R8: While `bus_sleep_i` is 1, `tx_ready_o` is 0 unless a wake-up sequence has completed since `bus_sleep_i` last rose.
- R9: While resync is set, `eng_reset_o` is 1, `tx_ready_o` is 0 and any running sequence is aborted, releasing `txd_o`. A wake request written together with resync is dropped. Normal operation resumes once resync is cleared.
- R10: A bit error, physical bus error or wake-up detection input pulses `eng_reset_o` high for one cycle in the next cycle when debug is 0. When debug is 1, these exceptions do not assert `eng_reset_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 5 | Control word to write (layout in R2) |
| rd_data_o | output | 5 | Control register readback |
| tx_busy_i | input | 1 | A frame transmission is in progress; writes are ignored |
| bit_tick_i | input | 1 | One-cycle strobe per bit time |
| bus_sleep_i | input | 1 | Bus is in sleep mode |
| exc_bit_err_i | input | 1 | Bit error detected by the engine |
| exc_phys_err_i | input | 1 | Physical bus error detected |
| exc_wake_det_i | input | 1 | Wake-up detected on the bus |
| txd_o | output | 1 | Transmit line contribution, 0 = dominant |
| tx_ready_o | output | 1 | Transmit may start |
| eng_reset_o | output | 1 | Hold or restart the protocol engine in its start state |

## Verification
A wake-up is run once for each of the four delimiter codes. This separates the four delimiter lengths and shows that the pulse length does not depend on the select. Second requests land inside the pulse and inside the delimiter, to tell dropping apart from queuing or restarting. Writes under `tx_busy_i`, the sleep input toggled before and after a completed wake-up, and resync set during a running pulse each show a different gate on transmit-ready. Exceptions are raised with debug clear and with debug set, so an automatic restart can be told apart from a suppressed one.

// File: rtl/lin_wake_pkg.sv
`timescale 1ns/1ps
package lin_wake_pkg;

   localparam int CTRL_W   = 5;
   localparam int F_RESYNC = 0;
   localparam int F_WAKE   = 1;
   localparam int F_SEL_LO = 2;
   localparam int F_DEBUG  = 4;
   localparam int SEL_W    = 2;
   localparam int SEL_N    = 1 << SEL_W;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_PULSE = 2'd1,
      PH_DELIM = 2'd2
   } phase_e;

endpackage

// File: rtl/lin_wake_ctrl_reg.sv
`timescale 1ns/1ps
module lin_wake_ctrl_reg
   import lin_wake_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   input  logic              tx_busy,
   output logic              resync_q,
   output logic              resync_d,
   output logic              debug_q,
   output logic              wake_req,
   output logic [SEL_W-1:0]  req_sel,
   output logic [CTRL_W-1:0] rd_data
);

   logic             accept;
   logic [SEL_W-1:0] sel_q;

   assign accept   = wr_en & ~tx_busy;
   assign resync_d = accept ? wr_data[F_RESYNC] : resync_q;
   assign wake_req = accept & wr_data[F_WAKE] & ~wr_data[F_RESYNC];
   assign req_sel  = wr_data[F_SEL_LO +: SEL_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resync_q <= 1'b0;
         debug_q  <= 1'b0;
         sel_q    <= '0;
      end else if (accept) begin
         resync_q <= wr_data[F_RESYNC];
         debug_q  <= wr_data[F_DEBUG];
         sel_q    <= wr_data[F_SEL_LO +: SEL_W];
      end
   end

   always_comb begin
      rd_data                      = '0;
      rd_data[F_RESYNC]            = resync_q;
      rd_data[F_SEL_LO +: SEL_W]   = sel_q;
      rd_data[F_DEBUG]             = debug_q;
   end

   // R3: a blocked write leaves the readback untouched
   p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && tx_busy) |=> $stable(rd_data));

endmodule

// File: rtl/lin_wake_seq.sv
`timescale 1ns/1ps
module lin_wake_seq
   import lin_wake_pkg::*;
#(
   parameter int PULSE_TICKS = 8,
   parameter int DLY_SEL0    = 4,
   parameter int DLY_SEL1    = 8,
   parameter int DLY_SEL2    = 32,
   parameter int DLY_SEL3    = 64,
   parameter int CNT_W       = 7
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             resync_q,
   input  logic             wake_req,
   input  logic [SEL_W-1:0] req_sel,
   input  logic             bit_tick,
   output phase_e           ph_q,
   output phase_e           ph_d,
   output logic             done
);

   localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_TICKS - 1);
   localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);

   initial begin
      assert (PULSE_TICKS >= 1) else $error("PULSE_TICKS must be at least 1");
      assert (DLY_SEL0 >= 1 && DLY_SEL1 >= 1 && DLY_SEL2 >= 1 && DLY_SEL3 >= 1)
         else $error("delimiter lengths must be at least 1");
      assert ((1 << CNT_W) > PULSE_TICKS) else $error("CNT_W too narrow");
   end

   function automatic int sel_ticks(int idx);
      case (idx)
         0:       return DLY_SEL0;
         1:       return DLY_SEL1;
         2:       return DLY_SEL2;
         default: return DLY_SEL3;
      endcase
   endfunction

   logic [CNT_W-1:0] dly_lut [SEL_N];

   for (genvar gi = 0; gi < SEL_N; gi++) begin : g_dly
      assign dly_lut[gi] = CNT_W'(sel_ticks(gi));
   end

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [CNT_W-1:0] len_q, len_d;

   always_comb begin
      ph_d  = ph_q;
      cnt_d = cnt_q;
      len_d = len_q;
      done  = 1'b0;
      if (resync_q) begin
         ph_d  = PH_IDLE;
         cnt_d = '0;
      end else begin
         case (ph_q)
            PH_IDLE: begin
               if (wake_req) begin
                  ph_d  = PH_PULSE;
                  cnt_d = '0;
                  len_d = dly_lut[req_sel];
               end
            end
            PH_PULSE: begin
               if (bit_tick) begin
                  if (cnt_q == PULSE_LAST) begin
                     ph_d  = PH_DELIM;
                     cnt_d = '0;
                  end else begin
                     cnt_d = cnt_q + CNT_ONE;
                  end
               end
            end
            PH_DELIM: begin
               if (bit_tick) begin
                  if (cnt_q + CNT_ONE == len_q) begin
                     ph_d  = PH_IDLE;
                     cnt_d = '0;
                     done  = 1'b1;
                  end else begin
                     cnt_d = cnt_q + CNT_ONE;
                  end
               end
            end
            default: begin
               ph_d  = PH_IDLE;
               cnt_d = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
         len_q <= '0;
      end else begin
         ph_q  <= ph_d;
         cnt_q <= cnt_d;
         len_q <= len_d;
      end
   end

   // R7: a request during the delimiter never restarts the pulse
   p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_DELIM && wake_req) |=> (ph_q != PH_PULSE));

endmodule

// File: rtl/lin_wake_gate.sv
`timescale 1ns/1ps
module lin_wake_gate
   import lin_wake_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  phase_e ph_d,
   input  logic   resync_d,
   input  logic   resync_q,
   input  logic   debug_q,
   input  logic   bus_sleep,
   input  logic   done,
   input  logic   exc_bit_err,
   input  logic   exc_phys_err,
   input  logic   exc_wake_det,
   output logic   tx_ready,
   output logic   eng_reset
);

   logic woke_q, woke_d;
   logic sleep_q;
   logic exc_q;
   logic exc_any;

   assign exc_any = exc_bit_err | exc_phys_err | exc_wake_det;

   always_comb begin
      if (done)                    woke_d = 1'b1;
      else if (bus_sleep & ~sleep_q) woke_d = 1'b0;
      else                         woke_d = woke_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         woke_q   <= 1'b0;
         sleep_q  <= 1'b0;
         exc_q    <= 1'b0;
         tx_ready <= 1'b0;
      end else begin
         woke_q   <= woke_d;
         sleep_q  <= bus_sleep;
         exc_q    <= exc_any & ~debug_q;
         tx_ready <= (ph_d == PH_IDLE) & ~resync_d & (~bus_sleep | woke_d);
      end
   end

   assign eng_reset = resync_q | exc_q;

   // R8: sleeping bus without a completed wake-up keeps ready low
   p_sleep_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bus_sleep) && !woke_q) |-> !tx_ready);

   // R10: exceptions restart the engine when debug is clear
   p_auto_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_any && !debug_q) |=> eng_reset);

endmodule

// File: rtl/lin_wake_ctrl.sv
`timescale 1ns/1ps
module lin_wake_ctrl
   import lin_wake_pkg::*;
#(
   parameter int PULSE_TICKS = 8,
   parameter int DLY_SEL0    = 4,
   parameter int DLY_SEL1    = 8,
   parameter int DLY_SEL2    = 32,
   parameter int DLY_SEL3    = 64
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [CTRL_W-1:0] wr_data_i,
   output logic [CTRL_W-1:0] rd_data_o,
   input  logic              tx_busy_i,
   input  logic              bit_tick_i,
   input  logic              bus_sleep_i,
   input  logic              exc_bit_err_i,
   input  logic              exc_phys_err_i,
   input  logic              exc_wake_det_i,
   output logic              txd_o,
   output logic              tx_ready_o,
   output logic              eng_reset_o
);

   localparam int MAX_A = (DLY_SEL0 > DLY_SEL1) ? DLY_SEL0 : DLY_SEL1;
   localparam int MAX_B = (DLY_SEL2 > DLY_SEL3) ? DLY_SEL2 : DLY_SEL3;
   localparam int MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int MAX_T = (MAX_D > PULSE_TICKS) ? MAX_D : PULSE_TICKS;
   localparam int CNT_W = $clog2(MAX_T + 1);

   logic             resync_q, resync_d, debug_q, wake_req, done;
   logic [SEL_W-1:0] req_sel;
   phase_e           ph_q, ph_d;

   lin_wake_ctrl_reg u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en_i),
      .wr_data  (wr_data_i),
      .tx_busy  (tx_busy_i),
      .resync_q (resync_q),
      .resync_d (resync_d),
      .debug_q  (debug_q),
      .wake_req (wake_req),
      .req_sel  (req_sel),
      .rd_data  (rd_data_o)
   );

   lin_wake_seq #(
      .PULSE_TICKS (PULSE_TICKS),
      .DLY_SEL0    (DLY_SEL0),
      .DLY_SEL1    (DLY_SEL1),
      .DLY_SEL2    (DLY_SEL2),
      .DLY_SEL3    (DLY_SEL3),
      .CNT_W       (CNT_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .resync_q (resync_q),
      .wake_req (wake_req),
      .req_sel  (req_sel),
      .bit_tick (bit_tick_i),
      .ph_q     (ph_q),
      .ph_d     (ph_d),
      .done     (done)
   );

   lin_wake_gate u_gate (
      .clk          (clk),
      .rst_n        (rst_n),
      .ph_d         (ph_d),
      .resync_d     (resync_d),
      .resync_q     (resync_q),
      .debug_q      (debug_q),
      .bus_sleep    (bus_sleep_i),
      .done         (done),
      .exc_bit_err  (exc_bit_err_i),
      .exc_phys_err (exc_phys_err_i),
      .exc_wake_det (exc_wake_det_i),
      .tx_ready     (tx_ready_o),
      .eng_reset    (eng_reset_o)
   );

   assign txd_o = (ph_q != PH_PULSE);

   // R4: an accepted request pulls the line dominant on the next cycle
   p_pulse_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_req && ph_q == PH_IDLE && !resync_q) |=> !txd_o);

   // R5: no ready while a pulse or delimiter is running
   p_ready_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q != PH_IDLE) |-> !tx_ready_o);

   // R9: a held resync keeps ready low and the line released
   p_resync_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (resync_q && $past(resync_q)) |-> (!tx_ready_o && txd_o && eng_reset_o));

endmodule

// File: tb/test_lin_wake_ctrl.sv
`timescale 1ns/1ps
module test_lin_wake_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [4:0] wr_data = '0;
   logic [4:0] rd_data;
   logic       tx_busy = 1'b0;
   logic       bit_tick = 1'b0;
   logic       bus_sleep = 1'b0;
   logic       exc_bit = 1'b0, exc_phys = 1'b0, exc_wake = 1'b0;
   logic       txd, tx_ready, eng_reset;

   always #2.5 clk = ~clk;

   lin_wake_ctrl i_lin_wake_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .wr_en_i        (wr_en),
      .wr_data_i      (wr_data),
      .rd_data_o      (rd_data),
      .tx_busy_i      (tx_busy),
      .bit_tick_i     (bit_tick),
      .bus_sleep_i    (bus_sleep),
      .exc_bit_err_i  (exc_bit),
      .exc_phys_err_i (exc_phys),
      .exc_wake_det_i (exc_wake),
      .txd_o          (txd),
      .tx_ready_o     (tx_ready),
      .eng_reset_o    (eng_reset)
   );

   int    n_chk = 0, n_err = 0, cyc = 0;
   string tag = "R1";
   bit    finished = 1'b0;

   task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   // bit strobe: one cycle high every tick_div cycles
   int tick_div = 3, tick_cnt = 0;
   always @(negedge clk) begin
      if (tick_cnt >= tick_div - 1) begin
         bit_tick = 1'b1;
         tick_cnt = 0;
      end else begin
         bit_tick = 1'b0;
         tick_cnt = tick_cnt + 1;
      end
   end

   // behavioural reference
   int m_ph, m_cnt, m_len, m_woke, m_exc, m_slp, m_sel, m_rs, m_dbg, m_rdy;
   bit chk_en = 1'b0;

   function automatic int dly_of(int s);
      case (s)
         0:       return 4;
         1:       return 8;
         2:       return 32;
         default: return 64;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_cnt = 0; m_len = 0; m_woke = 0; m_exc = 0;
         m_slp = 0; m_sel = 0; m_rs = 0; m_dbg = 0; m_rdy = 0;
         chk_en = 1'b0;
      end else begin : mdl
         bit acc, fin;
         int n_rs, n_ph, n_cnt, n_len, n_woke;
         acc = wr_en && !tx_busy;
         fin = 1'b0;
         n_rs = acc ? int'(wr_data[0]) : m_rs;
         n_ph = m_ph; n_cnt = m_cnt; n_len = m_len;
         if (m_rs != 0) begin
            n_ph = 0; n_cnt = 0;
         end else if (m_ph == 0) begin
            if (acc && wr_data[1] && !wr_data[0]) begin
               n_ph = 1; n_cnt = 0; n_len = dly_of(int'(wr_data[3:2]));
            end
         end else if (bit_tick) begin
            n_cnt = m_cnt + 1;
            if (m_ph == 1 && n_cnt == 8) begin
               n_ph = 2; n_cnt = 0;
            end else if (m_ph == 2 && n_cnt == m_len) begin
               n_ph = 0; n_cnt = 0; fin = 1'b1;
            end
         end
         if (fin) n_woke = 1;
         else if (bus_sleep && m_slp == 0) n_woke = 0;
         else n_woke = m_woke;
         m_rdy = (n_ph == 0 && n_rs == 0 && (!bus_sleep || n_woke != 0)) ? 1 : 0;
         m_exc = ((exc_bit || exc_phys || exc_wake) && m_dbg == 0) ? 1 : 0;
         if (acc) begin
            m_dbg = int'(wr_data[4]);
            m_sel = int'(wr_data[3:2]);
         end
         m_rs = n_rs; m_ph = n_ph; m_cnt = n_cnt; m_len = n_len; m_woke = n_woke;
         m_slp = bus_sleep ? 1 : 0;
         chk_en = 1'b1;
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (chk_en && rst_n && !finished) begin
         chk("txd", {7'd0, txd}, (m_ph == 1) ? 8'd0 : 8'd1);
         chk("tx_ready", {7'd0, tx_ready}, 8'(m_rdy));
         chk("eng_reset", {7'd0, eng_reset}, (m_rs != 0 || m_exc != 0) ? 8'd1 : 8'd0);
         chk("rd_data", {3'd0, rd_data},
             {3'd0, m_dbg[0], m_sel[1:0], 1'b0, m_rs[0]});
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !finished) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cyc);
         report();
      end
   end

   task automatic wr(logic [4:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      wr_data = '0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic exc_pulse(int which);
      @(negedge clk);
      exc_bit  = (which == 0);
      exc_phys = (which == 1);
      exc_wake = (which == 2);
      @(negedge clk);
      exc_bit = 1'b0; exc_phys = 1'b0; exc_wake = 1'b0;
   endtask

   initial begin
      // R1: reset values
      tag = "R1";
      idle(4);
      chk("reset txd", {7'd0, txd}, 8'd1);
      chk("reset tx_ready", {7'd0, tx_ready}, 8'd0);
      chk("reset eng_reset", {7'd0, eng_reset}, 8'd0);
      chk("reset rd_data", {3'd0, rd_data}, 8'd0);
      rst_n = 1'b1;
      idle(4);

      // R2: layout, readback, wake bit reads 0
      tag = "R2";
      wr(5'b1_10_1_0);
      idle(3);
      chk("wake bit reads 0", {7'd0, rd_data[1]}, 8'd0);
      idle(30 * 3 + 140);
      wr(5'b0_01_0_0);
      idle(3);

      // R4 R5 R6: each delimiter select
      for (int s = 0; s < 4; s++) begin
         tag = "R4 R5 R6";
         wr({1'b0, 2'(s), 1'b1, 1'b0});
         idle((8 + dly_of(s)) * 3 + 10);
      end

      // R3: writes blocked while transmitting
      tag = "R3";
      tx_busy = 1'b1;
      wr(5'b1_11_0_1);
      wr(5'b0_00_1_0);
      idle(6);
      tx_busy = 1'b0;
      idle(3);

      // R7: requests during pulse and delimiter are dropped
      tag = "R7";
      wr(5'b0_00_1_0);
      idle(6);
      wr(5'b0_11_1_0);
      idle(24);
      wr(5'b0_11_1_0);
      idle(40);

      // R8: sleep gating
      tag = "R8";
      bus_sleep = 1'b1;
      idle(6);
      wr(5'b0_00_1_0);
      idle(50);
      bus_sleep = 1'b0;
      idle(3);
      bus_sleep = 1'b1;
      idle(6);
      bus_sleep = 1'b0;
      idle(3);

      // R9: resync aborts and holds
      tag = "R9";
      wr(5'b0_01_1_0);
      idle(10);
      wr(5'b0_00_0_1);
      idle(8);
      wr(5'b0_00_0_0);
      idle(4);
      wr(5'b0_00_1_1);
      idle(30);
      wr(5'b0_00_0_0);
      idle(5);

      // R10: automatic restart and debug suppression
      tag = "R10";
      exc_pulse(0);
      idle(2);
      exc_pulse(1);
      idle(2);
      exc_pulse(2);
      idle(2);
      wr(5'b1_00_0_0);
      exc_pulse(0);
      idle(2);
      exc_pulse(1);
      idle(2);
      exc_pulse(2);
      idle(2);
      wr(5'b0_00_0_0);
      idle(4);

      report();
   end

endmodule